// File: doc/BRIEF.md
# NCO Frequency Hop Shadow Loader

This block manages the tuning word of one channel's numerically controlled oscillator. Software writes a 32-bit frequency word through a small register port. The word lands in an input holding register, moves to a shadow register on the next clock, and reaches the active frequency output only when a load is allowed. The phase accumulator that uses the word lies outside this block.

When the programmed hold-off is zero, every frequency write goes straight through to the output. When it is nonzero, the shadow waits for a trigger. The trigger is either a software hop command or a rising edge on a selected external sync pin. A 16-bit countdown then runs for the programmed number of clocks, and its terminal count copies the shadow into the active register. Several channels given the same trigger therefore change frequency on the same clock.

The sequencing is held in a two-state machine. In `HOP_IDLE`, an enabled trigger loads the counter from the hold-off value and moves the machine to `HOP_COUNT`. In `HOP_COUNT`, a new trigger reloads the counter and the machine stays where it is. Without a trigger, a count above one steps down by one. At a count of one or zero, the machine raises the load pulse and returns to `HOP_IDLE`.

Top module: `nco_hop_loader`

## Requirements
- R1: After reset the active frequency output `nco_freq` is zero, the hold-off value is zero and the configuration register is zero.
- R2: With hold-off zero, a word written to address 0 that is sampled at clock edge k appears on `nco_freq` after edge k+1.
- R3: With a nonzero hold-off, a frequency write on its own leaves `nco_freq` unchanged.
- R4: With hold-off N ≥ 1 (written at address 1, bits 15:0) and the soft-sync enable set (address 3 bit 0), a write to address 2 with bit 0 (hop) and bit 1 (sync) both high, sampled at edge k, copies the shadow to `nco_freq` at edge k+N. Before that edge `nco_freq` does not change.
- R5: A write to address 2 with only one of the hop and sync bits high starts no countdown and causes no load.
- R6: While the soft-sync enable is clear, a hop-and-sync write is ignored.
- R7: With the pin-sync enable set (address 3 bit 1) and pin select P set (address 3 bits 3:2), a rise of `sync_pin[P]` that is first sampled high at edge k loads the shadow into `nco_freq` at edge k+1+N.
- R8: A rise on a pin that is not selected, or any rise while the pin-sync enable is clear, causes no load.
- R9: The shadow may be rewritten during a countdown. The load at terminal count takes the shadow value held just before that edge.
- R10: A new trigger during a countdown restarts the count from the programmed hold-off. The load then happens N edges after the new trigger.
- R11: After terminal count the block is idle. A later frequency write with a nonzero hold-off does not reach `nco_freq` until another trigger arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address: 0 frequency, 1 hold-off, 2 command, 3 configuration |
| wr_data | input | 32 | Write data |
| sync_pin | input | 4 | External sync inputs |
| nco_freq | output | 32 | Active NCO frequency word |

## Verification
The assertions assume the hold-off value is not rewritten while a countdown is running. They also assume the sync pins are already synchronous to the master clock, so a single sampling stage is enough. The stimulus writes the hold-off only while the machine is in `HOP_IDLE`. It changes the sync pins only on falling clock edges and lowers them again between tests. Frequency rewrites during a countdown are placed at least two clocks before terminal count, so the expected shadow value is fixed.

// File: rtl/nco_hop_pkg.sv
package nco_hop_pkg;

    typedef enum logic [0:0] {
        HOP_IDLE  = 1'b0,
        HOP_COUNT = 1'b1
    } hop_state_e;

    localparam logic [1:0] ADDR_FREQ = 2'd0;
    localparam logic [1:0] ADDR_HOLD = 2'd1;
    localparam logic [1:0] ADDR_CMD  = 2'd2;
    localparam logic [1:0] ADDR_CFG  = 2'd3;

    localparam int CMD_HOP_BIT  = 0;
    localparam int CMD_SYNC_BIT = 1;
    localparam int CFG_SOFT_BIT = 0;
    localparam int CFG_PIN_BIT  = 1;
    localparam int CFG_SEL_LSB  = 2;

endpackage

// File: rtl/nco_hop_regs.sv
module nco_hop_regs
    import nco_hop_pkg::*;
#(
    parameter int FREQ_W = 32,
    parameter int HOLD_W = 16,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [FREQ_W-1:0] wr_data,
    output logic [FREQ_W-1:0] mport_q,
    output logic [FREQ_W-1:0] shadow_q,
    output logic              xfer_o,
    output logic [HOLD_W-1:0] holdoff_q,
    output logic              soft_en_q,
    output logic              pin_en_q,
    output logic [SEL_W-1:0]  pin_sel_q,
    output logic              soft_trig_o
);

    logic mport_vld_q;
    logic wr_freq, wr_hold, wr_cfg, wr_cmd;

    always_comb begin
        wr_freq = wr_en && (wr_addr == ADDR_FREQ);
        wr_hold = wr_en && (wr_addr == ADDR_HOLD);
        wr_cmd  = wr_en && (wr_addr == ADDR_CMD);
        wr_cfg  = wr_en && (wr_addr == ADDR_CFG);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mport_q     <= '0;
            mport_vld_q <= 1'b0;
            shadow_q    <= '0;
            holdoff_q   <= '0;
            soft_en_q   <= 1'b0;
            pin_en_q    <= 1'b0;
            pin_sel_q   <= '0;
        end else begin
            mport_vld_q <= wr_freq;
            if (wr_freq) mport_q <= wr_data;
            if (mport_vld_q) shadow_q <= mport_q;
            if (wr_hold) holdoff_q <= wr_data[HOLD_W-1:0];
            if (wr_cfg) begin
                soft_en_q <= wr_data[CFG_SOFT_BIT];
                pin_en_q  <= wr_data[CFG_PIN_BIT];
                pin_sel_q <= wr_data[CFG_SEL_LSB +: SEL_W];
            end
        end
    end

    always_comb begin
        xfer_o      = mport_vld_q;
        soft_trig_o = wr_cmd && soft_en_q
                      && wr_data[CMD_HOP_BIT] && wr_data[CMD_SYNC_BIT];
    end

    // R9
    shadow_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_o |=> (shadow_q == $past(mport_q)));

endmodule

// File: rtl/nco_hop_sync.sv
module nco_hop_sync #(
    parameter int NUM_PINS = 4,
    parameter int SEL_W    = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] sync_pin,
    input  logic                pin_en,
    input  logic [SEL_W-1:0]    pin_sel,
    output logic                rise_o
);

    logic [NUM_PINS-1:0] now_q;
    logic [NUM_PINS-1:0] prev_q;
    logic [NUM_PINS-1:0] rise_vec;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                now_q[p]  <= 1'b0;
                prev_q[p] <= 1'b0;
            end else begin
                now_q[p]  <= sync_pin[p];
                prev_q[p] <= now_q[p];
            end
        end
        assign rise_vec[p] = now_q[p] & ~prev_q[p];
    end

    always_comb begin
        rise_o = 1'b0;
        if (pin_en && (int'(pin_sel) < NUM_PINS)) rise_o = rise_vec[pin_sel];
    end

    // R8
    sync_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> pin_en);

    // R7
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o && $stable(pin_sel)) |=> !rise_o);

endmodule

// File: rtl/nco_hop_ctrl.sv
module nco_hop_ctrl
    import nco_hop_pkg::*;
#(
    parameter int HOLD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic [HOLD_W-1:0] holdoff_i,
    output logic              fire_o
);

    localparam logic [HOLD_W-1:0] ONE = HOLD_W'(1);

    hop_state_e        state_q, state_d;
    logic [HOLD_W-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HOP_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            HOP_IDLE: begin
                if (trig_i) begin
                    state_d = HOP_COUNT;
                    cnt_d   = holdoff_i;
                end
            end
            HOP_COUNT: begin
                if (trig_i) begin
                    cnt_d = holdoff_i;
                end else if (cnt_q <= ONE) begin
                    state_d = HOP_IDLE;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
            default: state_d = HOP_IDLE;
        endcase
    end

    always_comb begin
        fire_o = (state_q == HOP_COUNT) && !trig_i && (cnt_q <= ONE);
    end

    // R10
    cnt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_i |=> (cnt_q == $past(holdoff_i)) && (state_q == HOP_COUNT));

    // R4
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == HOP_COUNT && !trig_i && cnt_q > ONE) |=> (cnt_q == $past(cnt_q) - ONE));

    // R11
    idle_after_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> (state_q == HOP_IDLE) && !fire_o);

endmodule

// File: rtl/nco_hop_loader.sv
module nco_hop_loader #(
    parameter int FREQ_W   = 32,
    parameter int HOLD_W   = 16,
    parameter int NUM_PINS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          wr_addr,
    input  logic [FREQ_W-1:0]   wr_data,
    input  logic [NUM_PINS-1:0] sync_pin,
    output logic [FREQ_W-1:0]   nco_freq
);

    localparam int SEL_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    logic [FREQ_W-1:0] mport, shadow, active_q;
    logic              xfer, soft_en, pin_en, soft_trig, pin_trig, fire, direct;
    logic [HOLD_W-1:0] holdoff;
    logic [SEL_W-1:0]  pin_sel;

    nco_hop_regs #(.FREQ_W(FREQ_W), .HOLD_W(HOLD_W), .SEL_W(SEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .mport_q(mport), .shadow_q(shadow), .xfer_o(xfer), .holdoff_q(holdoff),
        .soft_en_q(soft_en), .pin_en_q(pin_en), .pin_sel_q(pin_sel),
        .soft_trig_o(soft_trig)
    );

    nco_hop_sync #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_sync (
        .clk(clk), .rst_n(rst_n), .sync_pin(sync_pin), .pin_en(pin_en),
        .pin_sel(pin_sel), .rise_o(pin_trig)
    );

    nco_hop_ctrl #(.HOLD_W(HOLD_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .trig_i(soft_trig | pin_trig),
        .holdoff_i(holdoff), .fire_o(fire)
    );

    always_comb direct = xfer && (holdoff == '0);

    always_ff @(posedge clk) begin
        if (!rst_n)      active_q <= '0;
        else if (direct) active_q <= mport;
        else if (fire)   active_q <= shadow;
    end

    assign nco_freq = active_q;

    // R2
    direct_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        direct |=> (nco_freq == $past(mport)));

    // R3
    hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!direct && !fire) |=> $stable(nco_freq));

endmodule

// File: tb/nco_hop_loader_test.sv
module nco_hop_loader_test;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [31:0] wr_data;
    logic [3:0]  sync_pin;
    logic [31:0] nco_freq;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;
    logic [31:0] cur;

    always #2.5 clk = ~clk;

    nco_hop_loader uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .sync_pin(sync_pin), .nco_freq(nco_freq)
    );

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] exp);
        n_chk++;
        if (nco_freq !== exp) begin
            n_fail++;
            $display("FAIL %s: nco_freq=%h expected %h", req, nco_freq, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int k);
        return (32'h9E37_79B9 * 32'(k)) ^ (32'(k) << 27);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; sync_pin = '0;
        repeat (3) @(negedge clk);
        chk("R1", 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", 32'h0);
        cur = 32'h0;

        // R2: hold-off zero, immediate path
        for (int k = 1; k <= 8; k++) begin
            logic [31:0] w;
            w = pat(k);
            wr(2'd0, w);
            chk("R2", cur);
            @(negedge clk);
            chk("R2", w);
            cur = w;
        end

        wr(2'd3, 32'h1);
        // R4 sweep of hold-off values with soft trigger; R3 before trigger
        for (int n = 1; n <= 12; n++) begin
            logic [31:0] w;
            w = pat(40 + n);
            wr(2'd1, 32'(n));
            wr(2'd0, w);
            idle(3);
            chk("R3", cur);
            wr(2'd2, 32'h3);
            chk("R4", cur);
            for (int i = 1; i < n; i++) begin
                @(negedge clk);
                chk("R4", cur);
            end
            @(negedge clk);
            chk("R4", w);
            cur = w;
        end

        // R5: only one of hop/sync
        begin
            logic [31:0] w;
            w = pat(100);
            wr(2'd1, 32'd4);
            wr(2'd0, w);
            wr(2'd2, 32'h1);
            idle(8);
            chk("R5", cur);
            wr(2'd2, 32'h2);
            idle(8);
            chk("R5", cur);
            // R6: soft enable clear
            wr(2'd3, 32'h0);
            wr(2'd2, 32'h3);
            idle(8);
            chk("R6", cur);
            wr(2'd3, 32'h1);
            wr(2'd2, 32'h3);
            idle(4);
            chk("R4", w);
            cur = w;
        end

        // R9: shadow rewritten during countdown
        begin
            logic [31:0] wa, wb, wc;
            wa = pat(200); wb = pat(201); wc = pat(202);
            wr(2'd1, 32'd8);
            wr(2'd0, wa);
            wr(2'd2, 32'h3);
            idle(2);
            wr(2'd0, wb);
            idle(4);
            chk("R9", cur);
            idle(1);
            chk("R9", wb);
            cur = wb;
            // R11: idle after terminal count
            wr(2'd0, wc);
            idle(15);
            chk("R11", cur);
            // R10: retrigger restarts the count
            wr(2'd1, 32'd10);
            wr(2'd2, 32'h3);
            idle(3);
            wr(2'd2, 32'h3);
            for (int i = 1; i <= 9; i++) begin
                @(negedge clk);
                chk("R10", cur);
            end
            @(negedge clk);
            chk("R10", wc);
            cur = wc;
        end

        // R7 / R8: pin sync over every pin select and a few hold-offs
        for (int sel = 0; sel < 4; sel++) begin
            for (int j = 0; j < 3; j++) begin
                int n;
                logic [31:0] w;
                n = (j == 0) ? 1 : ((j == 1) ? 3 : 6);
                w = pat(300 + sel * 8 + j);
                wr(2'd1, 32'(n));
                wr(2'd0, w);
                wr(2'd3, 32'h2 | (32'(sel) << 2));
                sync_pin[(sel + 1) % 4] = 1'b1;
                idle(6);
                chk("R8", cur);
                sync_pin[sel] = 1'b1;
                @(negedge clk);
                chk("R7", cur);
                for (int i = 1; i <= n; i++) begin
                    @(negedge clk);
                    chk("R7", cur);
                end
                @(negedge clk);
                chk("R7", w);
                cur = w;
                sync_pin = '0;
                idle(2);
            end
        end

        // R8: pin enable clear
        begin
            logic [31:0] w;
            w = pat(500);
            wr(2'd3, 32'h0);
            wr(2'd0, w);
            sync_pin = 4'hF;
            idle(10);
            chk("R8", cur);
            sync_pin = '0;
            idle(2);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule